// File: doc/BRIEF.md
# Sequenced Multi-Function Pin Controller

This block manages three shared pins. Each pin works either as an enable input, whose synchronized level is passed on to the rest of the chip, or as a general-purpose pin. In general-purpose mode, configuration bits set the direction, the output drive style (push-pull or open-drain), the output level and the pull-down. The synchronized level of every pin can always be read back.

An output pin can also be handed to a small power-up/power-down sequencer. The sequencer watches one chosen pin. A rising edge on that pin drives the output high after a start-up delay. A falling edge drives it low after a shutdown delay. Both delays are counted in pulses of an external delay tick. An edge that arrives while a delay is still running cancels the pending change.

Software reaches the configuration through a plain single-cycle write strobe and a combinational read mux. The pad interface is an output value, an output enable and a pull-down enable per pin, plus the raw pin input levels.

Top module: `seq_gpio_ctrl`

## Requirements
- R1: After reset, MODE (address 0) reads 0x00, DRIVE (address 1) reads 0x38, and every other configuration register reads 0x00. Each pin is then an enable input, its output enable is off and its pull-down is on.
- R2: MODE bits [2:0] choose the function of each pin (1 = general-purpose, 0 = enable). For a pin in enable function, en_out follows pad_in after two clock edges, and the output enable is 0.
- R3: STATUS (address 3) bits [2:0] return the pad_in levels after two clock edges of synchronization, whatever the pin function.
- R4: A general-purpose pin set to output (MODE bits [5:3] = 1) with push-pull style (DRIVE bits [2:0] = 0) has its output enable at 1 and its output equal to its LEVEL (address 2) bit, bits [2:0].
- R5: A general-purpose output in open-drain style (DRIVE bits [2:0] = 1) drives 0 with the output enable on when its level is 0. It releases the pin (output enable 0, output 0) when its level is 1.
- R6: pad_pd equals DRIVE bits [5:3], and it changes only when a register write occurs.
- R7: When SEQEN (address 4) bit p is set on a general-purpose output, a rising edge on the source pin makes the output rise after exactly N delay ticks. N is the start-up code in bits [3:0] of the delay register at address 6+p, and the output stays low before the N-th tick.
- R8: A falling edge on the source pin makes a sequenced output fall after exactly M delay ticks. M is the shutdown code in bits [7:4] of the same delay register.
- R9: A source edge that arrives while a delay is counting cancels the pending change, so the output keeps its level. A later edge starts a fresh delay.
- R10: A delay code of 0 applies the new level on the clock edge after the synchronized edge is seen, with no tick needed.
- R11: SRCSEL (address 5) holds a 2-bit source field per pin at bits [2p+1:2p]. Values 0 to 2 pick that pin's synchronized input as the source. Value 3 picks a constant low, so no edge ever occurs.
- R12: Writes to STATUS or to unused addresses change nothing. A pin that is not a general-purpose output never has its output enable on, whatever its LEVEL bit says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| dly_tick | input | 1 | One-cycle pulse that advances the sequence delays |
| pad_in | input | 3 | Raw pin input levels |
| pad_out | output | 3 | Pin output value |
| pad_oe | output | 3 | Pin output enable |
| pad_pd | output | 3 | Pin pull-down enable |
| en_out | output | 3 | Synchronized enable level for pins in enable function |

## Verification
The hardest case to reach from the ports is cancellation. A second source edge has to reach the sequencer while its countdown is still in flight, and the two-flop synchronizer adds latency before the edge is seen. The stimulus sets a start-up code of 3 and issues a single tick after the rising edge has settled through the synchronizer. It then drops the source pin and waits three clocks with the tick held low, so the opposite edge lands mid-count. After that, more ticks than the code are pulsed to show that the level never moved. A fresh edge then shows that the sequencer still works normally after a cancel.

// File: rtl/gpio_seq_pkg.sv
package gpio_seq_pkg;
    localparam int NPINS  = 3;
    localparam int DLY_W  = 4;
    localparam int SEL_W  = 2;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_MODE   = 4'd0;
    localparam logic [ADDR_W-1:0] A_DRIVE  = 4'd1;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 4'd2;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd3;
    localparam logic [ADDR_W-1:0] A_SEQEN  = 4'd4;
    localparam logic [ADDR_W-1:0] A_SRCSEL = 4'd5;
    localparam logic [ADDR_W-1:0] A_DLY0   = 4'd6;

    typedef struct packed {
        logic [NPINS-1:0]            gpio;
        logic [NPINS-1:0]            dir;
        logic [NPINS-1:0]            od;
        logic [NPINS-1:0]            pd;
        logic [NPINS-1:0]            lvl;
        logic [NPINS-1:0]            seq_en;
        logic [NPINS-1:0][SEL_W-1:0] src;
        logic [NPINS-1:0][DLY_W-1:0] up_dly;
        logic [NPINS-1:0][DLY_W-1:0] dn_dly;
    } cfg_t;

    typedef struct packed {
        logic             lvl;
        logic             busy;
        logic             tgt;
        logic             prev;
        logic [DLY_W-1:0] cnt;
    } seq_st_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = stg_q;
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [NPINS-1:0]  status,
    output logic [DATA_W-1:0] rdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            case (addr)
                A_MODE: begin
                    cfg_d.gpio = wdata[NPINS-1:0];
                    cfg_d.dir  = wdata[2*NPINS-1:NPINS];
                end
                A_DRIVE: begin
                    cfg_d.od = wdata[NPINS-1:0];
                    cfg_d.pd = wdata[2*NPINS-1:NPINS];
                end
                A_LEVEL:  cfg_d.lvl    = wdata[NPINS-1:0];
                A_SEQEN:  cfg_d.seq_en = wdata[NPINS-1:0];
                A_SRCSEL: cfg_d.src    = wdata[NPINS*SEL_W-1:0];
                default: begin
                    for (int p = 0; p < NPINS; p++) begin
                        if (addr == A_DLY0 + ADDR_W'(p)) begin
                            cfg_d.up_dly[p] = wdata[DLY_W-1:0];
                            cfg_d.dn_dly[p] = wdata[2*DLY_W-1:DLY_W];
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            cfg_q.pd <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:   rdata[2*NPINS-1:0]       = {cfg_q.dir, cfg_q.gpio};
            A_DRIVE:  rdata[2*NPINS-1:0]       = {cfg_q.pd, cfg_q.od};
            A_LEVEL:  rdata[NPINS-1:0]         = cfg_q.lvl;
            A_STATUS: rdata[NPINS-1:0]         = status;
            A_SEQEN:  rdata[NPINS-1:0]         = cfg_q.seq_en;
            A_SRCSEL: rdata[NPINS*SEL_W-1:0]   = cfg_q.src;
            default: begin
                for (int p = 0; p < NPINS; p++)
                    if (addr == A_DLY0 + ADDR_W'(p))
                        rdata = {cfg_q.dn_dly[p], cfg_q.up_dly[p]};
            end
        endcase
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/gpio_seq_ch.sv
module gpio_seq_ch
    import gpio_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             src,
    input  logic             tick,
    input  logic [DLY_W-1:0] up_code,
    input  logic [DLY_W-1:0] dn_code,
    output logic             level,
    output logic             busy,
    output logic             edge_seen
);
    seq_st_t st_d, st_q;
    logic [DLY_W-1:0] code;

    assign code      = src ? up_code : dn_code;
    assign edge_seen = active && (src != st_q.prev);

    always_comb begin
        st_d      = st_q;
        st_d.prev = src;
        if (!active) begin
            st_d.lvl  = 1'b0;
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (edge_seen) begin
            if (st_q.busy) begin
                st_d.busy = 1'b0;
            end else if (code == '0) begin
                st_d.lvl = src;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = code;
                st_d.tgt  = src;
            end
        end else if (st_q.busy && tick) begin
            if (st_q.cnt == DLY_W'(1)) begin
                st_d.lvl  = st_q.tgt;
                st_d.busy = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - DLY_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign busy  = st_q.busy;
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv (
    input  logic gpio,
    input  logic dir_out,
    input  logic od,
    input  logic reg_lvl,
    input  logic seq_act,
    input  logic seq_lvl,
    input  logic pd_cfg,
    output logic out,
    output logic oe,
    output logic pd
);
    logic lvl;

    always_comb begin
        lvl = seq_act ? seq_lvl : reg_lvl;
        out = 1'b0;
        oe  = 1'b0;
        if (gpio && dir_out) begin
            if (od) begin
                oe = !lvl;
            end else begin
                oe  = 1'b1;
                out = lvl;
            end
        end
    end

    assign pd = pd_cfg;
endmodule

// File: rtl/seq_gpio_ctrl.sv
module seq_gpio_ctrl
    import gpio_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dly_tick,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pd,
    output logic [NPINS-1:0]  en_out
);
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] seq_act, seq_src, seq_lvl, seq_busy, seq_edge;
    cfg_t cfg;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(pin_s)
    );

    gpio_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .status(pin_s), .rdata(reg_rdata), .cfg(cfg)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign seq_act[p] = cfg.gpio[p] && cfg.dir[p] && cfg.seq_en[p];
        assign seq_src[p] = (int'(cfg.src[p]) < NPINS) ? pin_s[cfg.src[p]] : 1'b0;

        gpio_seq_ch u_seq (
            .clk(clk), .rst_n(rst_n), .active(seq_act[p]), .src(seq_src[p]),
            .tick(dly_tick), .up_code(cfg.up_dly[p]), .dn_code(cfg.dn_dly[p]),
            .level(seq_lvl[p]), .busy(seq_busy[p]), .edge_seen(seq_edge[p])
        );

        gpio_pad_drv u_drv (
            .gpio(cfg.gpio[p]), .dir_out(cfg.dir[p]), .od(cfg.od[p]),
            .reg_lvl(cfg.lvl[p]), .seq_act(seq_act[p]), .seq_lvl(seq_lvl[p]),
            .pd_cfg(cfg.pd[p]), .out(pad_out[p]), .oe(pad_oe[p]), .pd(pad_pd[p])
        );

        assign en_out[p] = pin_s[p] && !cfg.gpio[p];
    end
endmodule

// File: rtl/seq_gpio_chk.sv
module seq_gpio_chk
    import gpio_seq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic             dly_tick,
    input logic [NPINS-1:0] gpio,
    input logic [NPINS-1:0] dir,
    input logic [NPINS-1:0] od,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pd,
    input logic [NPINS-1:0] seq_lvl,
    input logic [NPINS-1:0] seq_busy,
    input logic [NPINS-1:0] seq_edge
);
    AST_PD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(pad_pd)); // R6

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        AST_RELEASED_UNLESS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
            !(gpio[p] && dir[p]) |-> !pad_oe[p]); // R12
        AST_PP_ALWAYS_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
            (gpio[p] && dir[p] && !od[p]) |-> pad_oe[p]); // R4
        AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (gpio[p] && dir[p] && od[p]) |-> !pad_out[p]); // R5
        AST_WAIT_HOLDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_busy[p] && !dly_tick && !reg_we) |=> $stable(seq_lvl[p])); // R7
        AST_EDGE_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
            (seq_busy[p] && seq_edge[p] && !reg_we) |=> (!seq_busy[p] && $stable(seq_lvl[p]))); // R9
    end
endmodule

bind seq_gpio_ctrl seq_gpio_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .dly_tick(dly_tick),
    .gpio(cfg.gpio), .dir(cfg.dir), .od(cfg.od),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd),
    .seq_lvl(seq_lvl), .seq_busy(seq_busy), .seq_edge(seq_edge)
);

// File: tb/sim_seq_gpio_ctrl.sv
module sim_seq_gpio_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       dly_tick = 1'b0;
    logic [2:0] pad_in = '0;
    logic [2:0] pad_out, pad_oe, pad_pd, en_out;
    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    seq_gpio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dly_tick(dly_tick),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pd(pad_pd),
        .en_out(en_out)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            dly_tick = 1'b1;
            @(negedge clk);
            dly_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd0, v); chk("R1 mode", v, 8'h00);
        rd(4'd1, v); chk("R1 drive", v, 8'h38);
        rd(4'd7, v); chk("R1 delay", v, 8'h00);
        chk("R1 oe", 8'(pad_oe), 8'h0);
        chk("R6 pd reset", 8'(pad_pd), 8'h7);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        pad_in = 3'b101;
        @(posedge clk); @(negedge clk);
        chk("R2 one edge", 8'(en_out), 8'h0);
        @(posedge clk); @(negedge clk);
        chk("R2 en_out", 8'(en_out), 8'h5);
        rd(4'd3, v); chk("R3 status", v, 8'h05);
        chk("R2 oe", 8'(pad_oe), 8'h0);
    endtask

    task automatic t_ignored();
        logic [7:0] v;
        wr(4'd3, 8'hFF);
        wr(4'd15, 8'hFF);
        rd(4'd3, v); chk("R12 status write", v, 8'h05);
        rd(4'd0, v); chk("R12 unused write", v, 8'h00);
        wr(4'd2, 8'h07);
        chk("R12 enable mode oe", 8'(pad_oe), 8'h0);
        wr(4'd0, 8'h07);
        chk("R12 input dir oe", 8'(pad_oe), 8'h0);
    endtask

    task automatic t_pushpull();
        wr(4'd0, 8'h3F);
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h02);
        chk("R4 oe", 8'(pad_oe), 8'h7);
        chk("R4 out", 8'(pad_out), 8'h2);
        chk("R6 pd off", 8'(pad_pd), 8'h0);
    endtask

    task automatic t_opendrain();
        wr(4'd1, 8'h03);
        chk("R5 oe", 8'(pad_oe), 8'h5);
        chk("R5 out", 8'(pad_out), 8'h0);
        wr(4'd2, 8'h01);
        chk("R5 oe flip", 8'(pad_oe), 8'h6);
    endtask

    task automatic t_seq();
        pad_in = 3'b000;
        wr(4'd0, 8'h36);
        wr(4'd1, 8'h00);
        wr(4'd2, 8'h00);
        wr(4'd5, 8'h00);
        wr(4'd7, 8'h23);
        wr(4'd4, 8'h02);
        settle();
        pad_in[0] = 1'b1;
        settle();
        chk("R7 before ticks", 8'(pad_out[1]), 8'h0);
        tick(2);
        chk("R7 after 2 ticks", 8'(pad_out[1]), 8'h0);
        tick(1);
        chk("R7 after 3 ticks", 8'(pad_out[1]), 8'h1);
        pad_in[0] = 1'b0;
        settle();
        tick(1);
        chk("R8 after 1 tick", 8'(pad_out[1]), 8'h1);
        tick(1);
        chk("R8 after 2 ticks", 8'(pad_out[1]), 8'h0);
    endtask

    task automatic t_cancel();
        pad_in[0] = 1'b1;
        settle();
        tick(1);
        pad_in[0] = 1'b0;
        settle();
        tick(4);
        chk("R9 cancelled", 8'(pad_out[1]), 8'h0);
        pad_in[0] = 1'b1;
        settle();
        tick(3);
        chk("R9 fresh edge", 8'(pad_out[1]), 8'h1);
        pad_in[0] = 1'b0;
        settle();
        tick(2);
        chk("R9 back low", 8'(pad_out[1]), 8'h0);
    endtask

    task automatic t_zero();
        wr(4'd7, 8'h00);
        pad_in[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R10 not yet", 8'(pad_out[1]), 8'h0);
        @(posedge clk); @(negedge clk);
        chk("R10 rise", 8'(pad_out[1]), 8'h1);
        pad_in[0] = 1'b0;
        settle();
        chk("R10 fall", 8'(pad_out[1]), 8'h0);
    endtask

    task automatic t_select();
        wr(4'd5, 8'h0C);
        pad_in[0] = 1'b1;
        settle();
        chk("R11 select 3", 8'(pad_out[1]), 8'h0);
        wr(4'd5, 8'h08);
        pad_in[2] = 1'b1;
        settle();
        chk("R11 select pin2", 8'(pad_out[1]), 8'h1);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #800000;
        n_err++;
        $display("FAIL watchdog expired actual running expected done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable();
        t_ignored();
        t_pushpull();
        t_opendrain();
        t_seq();
        t_cancel();
        t_zero();
        t_select();
        summary();
    end
endmodule